// File: doc/BRIEF.md
# Branch Trace Message Generator

This block watches the stream of instructions a simple core retires, one per clock at most, and turns it into compact program-flow messages. Sequential instructions produce no message; they are only counted, so an off-chip tool can rebuild them from the program image. A message is produced when control flow leaves the sequential path: a taken branch, an indirect branch or an exception. Each message carries the count of instructions retired since the previous message and the address the flow went to.

Two message styles can be selected. In the individual style every taken branch produces its own message. In the history style direct branches only shift one outcome bit into a history register, and a message is produced on an indirect branch, on an exception, or when that register fills. Messages wait in an internal queue before a narrow trace port drains them with a valid/ready handshake. When the queue nears full, the block can ask the core to stall. If stalling is disabled, messages that do not fit are dropped, a pulse flags the loss, and the next instruction message is promoted to a resynchronisation message. Trace capture can begin at once or on a chosen watchpoint hit, and can end on another watchpoint hit. An external trigger event inserts a trigger message into the same ordered stream.

Top module: `branch_trace_gen`

## Requirements
- R1: While reset is held and on the first clock after it, msgValid, stallReq and ovf are all 0.
- R2: In individual style (histMode=0), a retired instruction of kind 1 (direct taken) or 3 (indirect) produces a message of type 0 carrying the current count and retAddr. Kinds 0 (sequential) and 2 (direct not taken) produce no message and add one to the count. Every message resets the count to 0.
- R3: An instruction of kind 4 (exception) produces a message of type 1 carrying the count and retAddr, in either style.
- R4: In history style (histMode=1), kinds 1 and 2 add one to the count and shift their outcome (1 = taken) into bit 0 of a HIST_W-bit history register. That register is reset to the value 1, which is a stop marker. Kind 3 produces a message of type 2 carrying the count, retAddr and the history register. Every message restores the history register to 1.
- R5: In history style, a direct branch that sets the top bit of the history register produces a type-2 message. That message carries the count including that branch, the shifted history and that branch's retAddr.
- R6: An instruction without a message of its own that would raise the count to 2^CNT_W-1 instead produces a type-3 message carrying that maximum count and retAddr. The count therefore never stays at its maximum.
- R7: A trigger pulse while capture is active queues a type-4 message with the count, history and address fields all 0. When it coincides with an instruction message, the trigger message comes after that message.
- R8: Messages leave the port in the order they were queued. The head message holds steady while msgValid=1 and msgReady=0.
- R9: With startOnWp=1, capture begins on the clock after wpHit[startWp]. With startOnWp=0, it begins on the clock after reset. With stopOnWp=1, capture ends on the clock after wpHit[stopWp] and does not restart until reset. While capture is inactive, no message is produced and the count stays 0.
- R10: With stallEn=1, stallReq rises on the clock after the queue occupancy is at least hwm. It falls on the clock after the occupancy is at most DEPTH/2, and it holds its value in between. With stallEn=0, stallReq is 0.
- R11: Acceptance is judged against the free space at the start of the cycle. The instruction message needs one free entry. The trigger message needs one more entry than the instruction message took. Any message that does not fit is dropped, and ovf pulses on the following clock.
- R12: After a drop, the next instruction message that is accepted is queued as type 3 regardless of its own kind. Trigger messages keep type 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | An instruction retires this cycle |
| retKind | input | 3 | Kind of retired instruction (0 seq, 1 direct taken, 2 direct not taken, 3 indirect, 4 exception) |
| retAddr | input | ADDR_W | Target or current address of the retired instruction |
| histMode | input | 1 | 1 selects the history style |
| trigIn | input | 1 | Trigger event pulse |
| wpHit | input | WP_N | Watchpoint hit pulses |
| startOnWp | input | 1 | Capture waits for a start watchpoint |
| startWp | input | WP_W | Index of the start watchpoint |
| stopOnWp | input | 1 | Capture ends on a stop watchpoint |
| stopWp | input | WP_W | Index of the stop watchpoint |
| stallEn | input | 1 | Enables the stall request |
| hwm | input | OCC_W | Occupancy at which stall is requested |
| msgReady | input | 1 | Trace port takes the head message |
| msgValid | output | 1 | Head message present |
| msgType | output | 3 | Message type (0 branch, 1 exception, 2 history, 3 resync, 4 trigger) |
| msgCnt | output | CNT_W | Instruction count field |
| msgHist | output | HIST_W | History field |
| msgAddr | output | ADDR_W | Address field |
| stallReq | output | 1 | Stall request to the core |
| ovf | output | 1 | A message was dropped on the previous clock |

## Verification
The assertions assume that hwm lies above DEPTH/2 and below DEPTH. They also assume that, while stallReq is high, the core retires nothing, and that the configuration inputs change only during reset. The stimulus respects these assumptions in several ways. It programs hwm well below full depth. It withholds retirement and trigger pulses whenever it sees stallReq high. It changes the style, the watchpoint selections and the stall enable only while reset is held. Overflow is provoked only with stalling disabled and the port blocked, so that drops and promoted resynchronisation messages can be observed.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [2:0] {
    RK_SEQ       = 3'd0,
    RK_DIR_TAKEN = 3'd1,
    RK_DIR_NOT   = 3'd2,
    RK_INDIRECT  = 3'd3,
    RK_EXCEPT    = 3'd4
  } retKind_e;

  typedef enum logic [2:0] {
    MT_BRANCH  = 3'd0,
    MT_EXCEPT  = 3'd1,
    MT_HIST    = 3'd2,
    MT_RESYNC  = 3'd3,
    MT_TRIGGER = 3'd4
  } msgType_e;

  // strobes from control to the message queue
  typedef struct packed {
    logic     pushIns;
    msgType_e insType;
    logic     pushTrig;
  } ctlStrobe_t;

endpackage

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int HIST_W = 8,
  parameter int DEPTH  = 16,
  parameter int WP_N   = 4,
  localparam int WP_W  = (WP_N > 1) ? $clog2(WP_N) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [2:0]        retKind,
  input  logic              histMode,
  input  logic              trigIn,
  input  logic [WP_N-1:0]   wpHit,
  input  logic              startOnWp,
  input  logic [WP_W-1:0]   startWp,
  input  logic              stopOnWp,
  input  logic [WP_W-1:0]   stopWp,
  input  logic              stallEn,
  input  logic [OCC_W-1:0]  hwm,
  input  logic [OCC_W-1:0]  occ,
  output ctlStrobe_t        strobe,
  output logic [CNT_W-1:0]  insCnt,
  output logic [HIST_W-1:0] insHist,
  output logic              stallReq
);

  localparam logic [CNT_W-1:0]  CNT_MAX    = '1;
  localparam logic [HIST_W-1:0] HIST_EMPTY = {{(HIST_W-1){1'b0}}, 1'b1};
  localparam logic [OCC_W-1:0]  HALF_OCC   = OCC_W'(DEPTH / 2);

  logic              traceOn, traceDone;
  logic [CNT_W-1:0]  icnt, icntNext, cntInc;
  logic [HIST_W-1:0] hist, histNext, histShift;
  retKind_e          kind;
  logic              isDirect, emit;
  msgType_e          emitType;

  // capture window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      traceOn   <= 1'b0;
      traceDone <= 1'b0;
    end else if (traceOn) begin
      if (stopOnWp && wpHit[stopWp]) begin
        traceOn   <= 1'b0;
        traceDone <= 1'b1;
      end
    end else if (!traceDone && (!startOnWp || wpHit[startWp])) begin
      traceOn <= 1'b1;
    end
  end

  // message decision for the retired instruction
  always_comb begin
    kind      = retKind_e'(retKind);
    isDirect  = (kind == RK_DIR_TAKEN) || (kind == RK_DIR_NOT);
    cntInc    = icnt + 1'b1;
    histShift = {hist[HIST_W-2:0], kind == RK_DIR_TAKEN};
    emit      = 1'b0;
    emitType  = MT_BRANCH;
    insCnt    = icnt;
    insHist   = hist;
    icntNext  = icnt;
    histNext  = hist;
    if (!traceOn) begin
      icntNext = '0;
      histNext = HIST_EMPTY;
    end else if (retValid) begin
      if (kind == RK_EXCEPT) begin
        emit     = 1'b1;
        emitType = MT_EXCEPT;
      end else if (kind == RK_INDIRECT) begin
        emit     = 1'b1;
        emitType = histMode ? MT_HIST : MT_BRANCH;
      end else if (!histMode && kind == RK_DIR_TAKEN) begin
        emit     = 1'b1;
      end else begin
        insCnt   = cntInc;
        icntNext = cntInc;
        if (histMode && isDirect) begin
          insHist  = histShift;
          histNext = histShift;
        end
        if (cntInc == CNT_MAX) begin
          emit     = 1'b1;
          emitType = MT_RESYNC;
        end else if (histMode && isDirect && histShift[HIST_W-1]) begin
          emit     = 1'b1;
          emitType = MT_HIST;
        end
      end
      if (emit) begin
        icntNext = '0;
        histNext = HIST_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      icnt <= '0;
      hist <= HIST_EMPTY;
    end else begin
      icnt <= icntNext;
      hist <= histNext;
    end
  end

  assign strobe.pushIns  = emit;
  assign strobe.insType  = emitType;
  assign strobe.pushTrig = traceOn && trigIn;

  // stall request with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN || !stallEn) stallReq <= 1'b0;
    else if (occ >= hwm) stallReq <= 1'b1;
    else if (occ <= HALF_OCC) stallReq <= 1'b0;
  end

  // R6: count register never rests at its ceiling
  p_cnt_below_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    icnt != CNT_MAX);

  // R9: nothing is queued once the capture window has closed
  p_quiet_after_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    traceDone |-> (!strobe.pushIns && !strobe.pushTrig));

  // R10: request rises only from a high occupancy
  p_stall_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallReq) |-> ($past(occ) >= $past(hwm)));

  // R10: request drops only at half depth or when disabled
  p_stall_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stallReq) |-> (($past(occ) <= HALF_OCC) || !$past(stallEn)));

endmodule

// File: rtl/btm_fifo.sv
module btm_fifo
  import btm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int HIST_W = 8,
  parameter int DEPTH  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = 3 + CNT_W + HIST_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [CNT_W-1:0]  insCnt,
  input  logic [HIST_W-1:0] insHist,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic              msgReady,
  output logic              msgValid,
  output logic [2:0]        msgType,
  output logic [CNT_W-1:0]  msgCnt,
  output logic [HIST_W-1:0] msgHist,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [OCC_W-1:0]  occ,
  output logic              ovf
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrB;
  logic [OCC_W-1:0] count, free;
  logic             acceptA, acceptB, pop, drop, lost;
  msgType_e         typeA;
  logic [ENT_W-1:0] entA, entB;

  always_comb begin
    free    = OCC_W'(DEPTH) - count;
    acceptA = strobe.pushIns && (free != '0);
    acceptB = strobe.pushTrig && (acceptA ? (free >= OCC_W'(2)) : (free != '0));
    drop    = (strobe.pushIns && !acceptA) || (strobe.pushTrig && !acceptB);
    pop     = msgReady && (count != '0);
    typeA   = lost ? MT_RESYNC : strobe.insType;
    entA    = {typeA, insCnt, insHist, insAddr};
    entB    = {MT_TRIGGER, {CNT_W{1'b0}}, {HIST_W{1'b0}}, {ADDR_W{1'b0}}};
    wrPtrB  = wrPtr + PTR_W'(acceptA);
  end

  always_ff @(posedge clk) begin
    if (acceptA) mem[wrPtr] <= entA;
    if (acceptB) mem[wrPtrB] <= entB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      lost  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(acceptA) + PTR_W'(acceptB);
      rdPtr <= rdPtr + PTR_W'(pop);
      count <= count + OCC_W'(acceptA) + OCC_W'(acceptB) - OCC_W'(pop);
      ovf   <= drop;
      if (drop) lost <= 1'b1;
      else if (acceptA) lost <= 1'b0;
    end
  end

  assign msgValid = (count != '0);
  assign {msgType, msgCnt, msgHist, msgAddr} = mem[rdPtr];
  assign occ = count;

  // R8: a stalled head message stays put
  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgType) && $stable(msgCnt)
                                 && $stable(msgHist) && $stable(msgAddr)));

  // R11: occupancy bounded by depth
  p_occ_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  // R11: a loss is reported only after a nearly full queue
  p_ovf_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> ($past(occ) >= OCC_W'(DEPTH - 1)));

endmodule

// File: rtl/branch_trace_gen.sv
module branch_trace_gen
  import btm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int HIST_W = 8,
  parameter int DEPTH  = 16,
  parameter int WP_N   = 4,
  localparam int WP_W  = (WP_N > 1) ? $clog2(WP_N) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [2:0]        retKind,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic              histMode,
  input  logic              trigIn,
  input  logic [WP_N-1:0]   wpHit,
  input  logic              startOnWp,
  input  logic [WP_W-1:0]   startWp,
  input  logic              stopOnWp,
  input  logic [WP_W-1:0]   stopWp,
  input  logic              stallEn,
  input  logic [OCC_W-1:0]  hwm,
  input  logic              msgReady,
  output logic              msgValid,
  output logic [2:0]        msgType,
  output logic [CNT_W-1:0]  msgCnt,
  output logic [HIST_W-1:0] msgHist,
  output logic [ADDR_W-1:0] msgAddr,
  output logic              stallReq,
  output logic              ovf
);

  ctlStrobe_t        strobe;
  logic [CNT_W-1:0]  insCnt;
  logic [HIST_W-1:0] insHist;
  logic [OCC_W-1:0]  occ;

  btm_ctrl #(.CNT_W(CNT_W), .HIST_W(HIST_W), .DEPTH(DEPTH), .WP_N(WP_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retKind(retKind),
    .histMode(histMode), .trigIn(trigIn), .wpHit(wpHit),
    .startOnWp(startOnWp), .startWp(startWp), .stopOnWp(stopOnWp), .stopWp(stopWp),
    .stallEn(stallEn), .hwm(hwm), .occ(occ),
    .strobe(strobe), .insCnt(insCnt), .insHist(insHist), .stallReq(stallReq)
  );

  btm_fifo #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HIST_W(HIST_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insCnt(insCnt), .insHist(insHist),
    .insAddr(retAddr), .msgReady(msgReady), .msgValid(msgValid), .msgType(msgType),
    .msgCnt(msgCnt), .msgHist(msgHist), .msgAddr(msgAddr), .occ(occ), .ovf(ovf)
  );

endmodule

// File: tb/branch_trace_gen_tb.sv
module branch_trace_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 6;
  localparam int HIST_W = 8;
  localparam int DEPTH  = 16;
  localparam int WP_N   = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 0, rstN = 0;
  logic retValid = 0, histMode = 0, trigIn = 0, startOnWp = 0, stopOnWp = 0;
  logic stallEn = 0, msgReady = 1;
  logic [2:0] retKind = 0;
  logic [ADDR_W-1:0] retAddr = 0;
  logic [WP_N-1:0] wpHit = 0;
  logic [1:0] startWp = 0, stopWp = 0;
  logic [4:0] hwm = 5'd12;
  logic msgValid, stallReq, ovf;
  logic [2:0] msgType;
  logic [CNT_W-1:0] msgCnt;
  logic [HIST_W-1:0] msgHist;
  logic [ADDR_W-1:0] msgAddr;

  int tests = 0, fails = 0, ovfSeen = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_trace_gen u_dut (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retKind(retKind), .retAddr(retAddr),
    .histMode(histMode), .trigIn(trigIn), .wpHit(wpHit), .startOnWp(startOnWp),
    .startWp(startWp), .stopOnWp(stopOnWp), .stopWp(stopWp), .stallEn(stallEn),
    .hwm(hwm), .msgReady(msgReady), .msgValid(msgValid), .msgType(msgType),
    .msgCnt(msgCnt), .msgHist(msgHist), .msgAddr(msgAddr), .stallReq(stallReq), .ovf(ovf)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { int t; int c; int h; logic [ADDR_W-1:0] a; } item_t;
  item_t q[$];
  int mIcnt, mHist;
  bit mOn, mDone, mStall, mOvf, mLost;

  always @(posedge clk) begin
    int pre, free, k, c, h;
    bit ins, dir, drop, accA;
    item_t it, tr;
    if (!rstN) begin
      q.delete(); mOn = 0; mDone = 0; mIcnt = 0; mHist = 1;
      mStall = 0; mOvf = 0; mLost = 0;
    end else begin
      pre = q.size();
      ins = 0; it = '{0, 0, 0, '0};
      if (mOn && retValid) begin
        k = int'(retKind);
        dir = (k == 1) || (k == 2);
        if (k == 4) begin ins = 1; it = '{1, mIcnt, mHist, retAddr}; end
        else if (k == 3) begin ins = 1; it = '{histMode ? 2 : 0, mIcnt, mHist, retAddr}; end
        else if (!histMode && k == 1) begin ins = 1; it = '{0, mIcnt, mHist, retAddr}; end
        else begin
          c = mIcnt + 1; h = mHist;
          if (histMode && dir) h = ((mHist << 1) | (k == 1 ? 1 : 0)) & ((1 << HIST_W) - 1);
          if (c == CMAX) begin ins = 1; it = '{3, c, h, retAddr}; end
          else if (histMode && dir && h >= (1 << (HIST_W - 1))) begin ins = 1; it = '{2, c, h, retAddr}; end
          else begin mIcnt = c; mHist = h; end
        end
        if (ins) begin mIcnt = 0; mHist = 1; end
      end
      if (!mOn) begin mIcnt = 0; mHist = 1; end
      // stall register from the occupancy at the start of the cycle
      if (!stallEn) mStall = 0;
      else if (pre >= int'(hwm)) mStall = 1;
      else if (pre <= DEPTH / 2) mStall = 0;
      if (msgReady && pre > 0) void'(q.pop_front());
      free = DEPTH - pre; drop = 0; accA = 0;
      if (ins) begin
        if (free >= 1) begin
          if (mLost) it.t = 3;
          q.push_back(it); free--; accA = 1;
        end else drop = 1;
      end
      if (mOn && trigIn) begin
        if (free >= 1) begin tr = '{4, 0, 0, '0}; q.push_back(tr); free--; end
        else drop = 1;
      end
      if (drop) mLost = 1; else if (accA) mLost = 0;
      mOvf = drop;
      if (mOn) begin
        if (stopOnWp && wpHit[stopWp]) begin mOn = 0; mDone = 1; end
      end else if (!mDone && (!startOnWp || wpHit[startWp])) mOn = 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(msgValid == (q.size() != 0), phase, "msgValid", msgValid, q.size() != 0);
      if (msgValid && q.size() != 0) begin
        chk(msgType == q[0].t[2:0], phase, "msgType", msgType, q[0].t);
        chk(msgCnt == q[0].c[CNT_W-1:0], phase, "msgCnt", msgCnt, q[0].c);
        chk(msgHist == q[0].h[HIST_W-1:0], phase, "msgHist", msgHist, q[0].h);
        chk(msgAddr == q[0].a, phase, "msgAddr", msgAddr, q[0].a);
      end
      chk(stallReq == mStall, phase, "stallReq", stallReq, mStall);
      chk(ovf == mOvf, phase, "ovf", ovf, mOvf);
      if (ovf) ovfSeen++;
    end
  end

  task automatic step(bit v, int k, int a, bit trg);
    @(negedge clk);
    while (stallReq) begin retValid = 0; trigIn = 0; @(negedge clk); end
    retValid = v; retKind = k[2:0]; retAddr = ADDR_W'(a); trigIn = trg;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic pulseWp(int idx);
    @(negedge clk);
    retValid = 0; trigIn = 0; wpHit = WP_N'(1 << idx);
    @(negedge clk);
    wpHit = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; retValid = 0; trigIn = 0; wpHit = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    finishRun();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(msgValid == 0, "R1", "msgValid in reset", msgValid, 0);
    chk(stallReq == 0, "R1", "stallReq in reset", stallReq, 0);
    chk(ovf == 0, "R1", "ovf in reset", ovf, 0);
    rstN = 1;
    @(negedge clk);
    chk(msgValid == 0 && stallReq == 0 && ovf == 0, "R1", "outputs after release", 0, 0);
    idle(2);

    phase = "R2 individual branches";
    for (int i = 0; i < 3; i++) step(1, 0, 'h100 + i * 4, 0);
    step(1, 2, 'h10c, 0); step(1, 0, 'h110, 0); step(1, 1, 'h2000, 0);
    step(1, 3, 'h3000, 0); step(1, 0, 'h3004, 0); step(1, 1, 'h4000, 0);
    idle(4);

    phase = "R3 exception";
    step(1, 0, 'h4004, 0); step(1, 4, 'h500, 0); idle(3);

    phase = "R7 trigger ordering";
    step(1, 0, 'h504, 0); step(1, 1, 'h600, 1); step(0, 0, 0, 1); step(1, 0, 'h604, 1);
    idle(4);

    phase = "R6 count saturation";
    for (int i = 0; i < 2 * CMAX + 5; i++) step(1, (i % 5 == 0) ? 2 : 0, 'h7000 + i * 4, 0);
    idle(4);

    phase = "R4 history style";
    doReset(); histMode = 1; idle(2);
    step(1, 0, 'h10, 0); step(1, 1, 'h40, 0); step(1, 2, 'h44, 0); step(1, 1, 'h80, 0);
    step(1, 3, 'h900, 0); step(1, 1, 'h910, 0); step(1, 4, 'ha00, 0);
    idle(4);

    phase = "R5 history full";
    for (int i = 0; i < 3 * (HIST_W - 1); i++) step(1, (i % 3 == 0) ? 2 : 1, 'hb00 + i * 8, 0);
    idle(4);
    phase = "R6 saturation in history style";
    for (int i = 0; i < CMAX + 2; i++) step(1, 0, 'hc000 + i * 4, 0);
    idle(4);

    phase = "R8 port backpressure";
    for (int i = 0; i < 400; i++) begin
      step(1, $urandom % 5, $urandom, ($urandom % 8) == 0);
      msgReady = ($urandom % 3) != 0;
    end
    msgReady = 1; idle(20);

    phase = "R11 overflow";
    doReset(); histMode = 0; stallEn = 0; idle(2);
    msgReady = 0;
    for (int i = 0; i < DEPTH + 6; i++) step(1, 1, 'hd000 + i * 16, i == DEPTH);
    idle(2);
    chk(ovfSeen > 0, "R11", "ovf pulses seen", ovfSeen, 1);
    msgReady = 1; idle(DEPTH + 4);
    phase = "R12 resync after loss";
    step(1, 0, 'he000, 0); step(1, 1, 'he100, 1); step(1, 1, 'he200, 0);
    idle(6);

    phase = "R10 stall hysteresis";
    doReset(); stallEn = 1; hwm = 5'd10; idle(2);
    base = ovfSeen;
    msgReady = 0;
    fork
      for (int i = 0; i < 40; i++) step(1, 1, 'hf000 + i * 4, 0);
      begin repeat (60) @(negedge clk); msgReady = 1; end
    join
    idle(DEPTH + 4);
    chk(ovfSeen == base, "R10", "no loss while stalling", ovfSeen - base, 0);
    chk(stallReq == 0, "R10", "stall released after drain", stallReq, 0);

    phase = "R9 capture window";
    doReset(); stallEn = 0; startOnWp = 1; startWp = 2; stopOnWp = 1; stopWp = 1;
    idle(2);
    for (int i = 0; i < 5; i++) step(1, 1, 'h100 + i, 1);
    idle(2);
    chk(msgValid == 0, "R9", "no message before start hit", msgValid, 0);
    pulseWp(2);
    for (int i = 0; i < 4; i++) step(1, (i == 2) ? 1 : 0, 'h200 + i * 4, 0);
    idle(4);
    pulseWp(1);
    for (int i = 0; i < 5; i++) step(1, 3, 'h300 + i, 1);
    pulseWp(2);
    step(1, 1, 'h400, 0);
    idle(4);
    chk(msgValid == 0, "R9", "no message after stop hit", msgValid, 0);

    finishRun();
  end

endmodule